// File: doc/BRIEF.md
# Dual-Port Interleaving Converter Input Controller

This block sits in front of a converter's data latch and feeds it from two parallel 12-bit input ports. It runs on one full-rate clock. In interleave mode it splits that clock internally into a half-rate capture phase. On each half-rate rising edge it samples both ports. It then presents the two captured words to the output latch on consecutive full-rate cycles: the first port's word first, then the second port's word. In either single-port mode, the chosen port is registered straight through at the full clock rate.

A synchronous active-high reset pins the divider to a known phase, so the data source can line its port updates up with the capture edges. A status output carries the half-rate phase, delayed by one full-rate cycle, as an alignment reference. A two-bit mode code picks the operating mode. The code `11` is illegal: while it is active, the output freezes and an error flag is raised. A new mode code is taken only on a half-rate capture edge, so a mode switch never splits a captured pair.

Top module: `dac_ilv_ctrl`

## Requirements
- R1: While `rst_i` is high at a rising edge, after that edge `dac_o` is 0x800, `phase_mon_o` is 0 and `mode_err_o` is 0. The divider is held at phase zero, and the active mode becomes interleave (00).
- R2: After reset is released, the capture edges are the 1st, 3rd, 5th, … rising edges. These are the edges at which the port latches load and the mode code is taken.
- R3: In mode 00 (interleave), the `port1_i` word captured at a capture edge appears on `dac_o` after the next rising edge. The `port2_i` word from the same capture appears after the edge after that.
- R4: `phase_mon_o` equals the internal half-rate phase delayed by one full-rate cycle. Counting rising edges from reset release as n = 1, 2, …, it is 0 after odd n and 1 after even n.
- R5: In mode 01 (first port only), `dac_o` after each rising edge equals `port1_i` as sampled at that edge.
- R6: In mode 10 (second port only), `dac_o` after each rising edge equals `port2_i` as sampled at that edge.
- R7: While the active mode is 11, `dac_o` holds its previous value across every edge.
- R8: A change of `mode_i` becomes the active mode only at a capture edge. A change presented at any other edge has no effect until the next capture edge.
- R9: `mode_err_o` is 1 exactly while the active mode is 11. It is cleared by the capture edge that takes a legal code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Full-rate clock (output update rate) |
| rst_i | input | 1 | Synchronous active-high reset, fixes divider phase |
| mode_i | input | 2 | Mode code: 00 interleave, 01 first port, 10 second port, 11 illegal |
| port1_i | input | 12 | First input data port |
| port2_i | input | 12 | Second input data port |
| dac_o | output | 12 | Output data latch to the converter |
| phase_mon_o | output | 1 | Half-rate phase delayed by one full-rate cycle |
| mode_err_o | output | 1 | High while the illegal mode code is active |

## Verification
The delicate coincidence is a mode change arriving on the same capture edge that emits the second word of a pair. At that edge the old mode must still pick the output while the new mode is latched for the following cycles. The bench provokes this by changing `mode_i` on every cycle over a stretch, and by changing it at random offsets relative to the half-rate phase. A second coincidence is reset arriving mid-pair. Both are judged by a cycle-accurate behavioural model that follows the requirements, compared against every output on every clock.

// File: rtl/dac_ilv_pkg.sv
package dac_ilv_pkg;

    typedef enum logic [1:0] {
        MODE_ILV = 2'b00,
        MODE_P1  = 2'b01,
        MODE_P2  = 2'b10,
        MODE_BAD = 2'b11
    } mode_e;

endpackage

// File: rtl/dac_half_clk.sv
module dac_half_clk (
    input  logic clk_i,
    input  logic rst_i,
    output logic ph_o,
    output logic mon_o
);

    typedef struct packed {
        logic ph;
        logic mon;
    } hc_state_t;

    hc_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.ph  = ~st_q.ph;
        st_d.mon = st_q.ph;
        if (rst_i) begin
            st_d.ph  = 1'b0;
            st_d.mon = 1'b0;
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign ph_o  = st_q.ph;
    assign mon_o = st_q.mon;

    AST_MON_DELAY: assert property (@(posedge clk_i) disable iff (rst_i)
        !$past(rst_i) |-> (mon_o == $past(ph_o))); // R4

    AST_PHASE_ZERO: assert property (@(posedge clk_i)
        rst_i |=> (ph_o == 1'b0 && mon_o == 1'b0)); // R1

endmodule

// File: rtl/dac_port_latch.sv
module dac_port_latch
    import dac_ilv_pkg::*;
#(
    parameter int DW = 12
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          ph_i,
    input  logic [1:0]    mode_i,
    input  logic [DW-1:0] p1_i,
    input  logic [DW-1:0] p2_i,
    output logic [DW-1:0] lat1_o,
    output logic [DW-1:0] lat2_o,
    output mode_e         mode_o
);

    localparam logic [DW-1:0] MID = {1'b1, {(DW-1){1'b0}}};

    typedef struct packed {
        logic [DW-1:0] lat1;
        logic [DW-1:0] lat2;
        mode_e         mode;
    } cap_state_t;

    cap_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!ph_i) begin
            st_d.lat1 = p1_i;
            st_d.lat2 = p2_i;
            st_d.mode = mode_e'(mode_i);
        end
        if (rst_i) begin
            st_d.lat1 = MID;
            st_d.lat2 = MID;
            st_d.mode = MODE_ILV;
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign lat1_o = st_q.lat1;
    assign lat2_o = st_q.lat2;
    assign mode_o = st_q.mode;

    AST_MODE_ON_CAPTURE: assert property (@(posedge clk_i) disable iff (rst_i)
        !$past(rst_i) && (mode_o != $past(mode_o)) |-> ($past(ph_i) == 1'b0)); // R8

    AST_LATCH_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        ph_i |=> $stable(lat1_o) && $stable(lat2_o)); // R2

endmodule

// File: rtl/dac_out_sel.sv
module dac_out_sel
    import dac_ilv_pkg::*;
#(
    parameter int DW = 12
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          ph_i,
    input  mode_e         mode_i,
    input  logic [DW-1:0] lat1_i,
    input  logic [DW-1:0] lat2_i,
    input  logic [DW-1:0] p1_i,
    input  logic [DW-1:0] p2_i,
    output logic [DW-1:0] dac_o
);

    localparam logic [DW-1:0] MID = {1'b1, {(DW-1){1'b0}}};

    typedef struct packed {
        logic [DW-1:0] dac;
    } out_state_t;

    out_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        case (mode_i)
            MODE_ILV: st_d.dac = ph_i ? lat1_i : lat2_i;
            MODE_P1:  st_d.dac = p1_i;
            MODE_P2:  st_d.dac = p2_i;
            MODE_BAD: st_d.dac = st_q.dac;
            default:  st_d.dac = st_q.dac;
        endcase
        if (rst_i) begin
            st_d.dac = MID;
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign dac_o = st_q.dac;

    AST_BAD_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode_i == MODE_BAD) |=> $stable(dac_o)); // R7

    AST_FIRST_WORD: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode_i == MODE_ILV) && ph_i |=> (dac_o == $past(lat1_i))); // R3

    AST_RESET_MID: assert property (@(posedge clk_i)
        rst_i |=> (dac_o == MID)); // R1

endmodule

// File: rtl/dac_ilv_ctrl.sv
module dac_ilv_ctrl
    import dac_ilv_pkg::*;
#(
    parameter int DW = 12
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic [1:0]    mode_i,
    input  logic [DW-1:0] port1_i,
    input  logic [DW-1:0] port2_i,
    output logic [DW-1:0] dac_o,
    output logic          phase_mon_o,
    output logic          mode_err_o
);

    logic          ph;
    logic [DW-1:0] lat1, lat2;
    mode_e         mode_q;

    dac_half_clk u_half (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .ph_o  (ph),
        .mon_o (phase_mon_o)
    );

    dac_port_latch #(.DW(DW)) u_cap (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .ph_i   (ph),
        .mode_i (mode_i),
        .p1_i   (port1_i),
        .p2_i   (port2_i),
        .lat1_o (lat1),
        .lat2_o (lat2),
        .mode_o (mode_q)
    );

    dac_out_sel #(.DW(DW)) u_out (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .ph_i   (ph),
        .mode_i (mode_q),
        .lat1_i (lat1),
        .lat2_i (lat2),
        .p1_i   (port1_i),
        .p2_i   (port2_i),
        .dac_o  (dac_o)
    );

    assign mode_err_o = (mode_q == MODE_BAD);

    AST_ERR_ON_CAPTURE: assert property (@(posedge clk_i) disable iff (rst_i)
        !$past(rst_i) && $rose(mode_err_o) |-> ($past(mode_i) == 2'b11)); // R9

endmodule

// File: tb/dac_ilv_ctrl_bench.sv
module dac_ilv_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  mode;
    logic [11:0] pa, pb;
    logic [11:0] dac;
    logic        mon, err;

    always #10 clk = ~clk;

    dac_ilv_ctrl u_dac_ilv_ctrl (
        .clk_i       (clk),
        .rst_i       (rst),
        .mode_i      (mode),
        .port1_i     (pa),
        .port2_i     (pb),
        .dac_o       (dac),
        .phase_mon_o (mon),
        .mode_err_o  (err)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    // behavioural reference model
    logic [11:0] m_out, m_la, m_lb;
    logic [1:0]  m_md;
    int          m_cyc;
    logic        m_stat, m_err, m_valid = 0, m_inrst;
    string       m_tag;

    always @(posedge clk) begin
        m_valid <= 1'b1;
        if (rst) begin
            m_out = 12'h800; m_la = 12'h800; m_lb = 12'h800;
            m_md = 2'b00; m_cyc = 0; m_stat = 0; m_err = 0;
            m_inrst = 1; m_tag = "R1";
        end else begin
            bit capture;
            m_inrst = 0;
            capture = (m_cyc % 2 == 0);          // R2: capture on 1st, 3rd, ... edges
            case (m_md)
                2'b00: begin m_out = capture ? m_lb : m_la; m_tag = "R3"; end
                2'b01: begin m_out = pa; m_tag = "R5"; end
                2'b10: begin m_out = pb; m_tag = "R6"; end
                default: m_tag = "R7";           // hold
            endcase
            if (capture) begin
                if (mode != m_md) m_tag = {m_tag, " R8"};
                m_la = pa; m_lb = pb; m_md = mode;
            end
            m_stat = (m_cyc % 2 == 1);           // R4
            m_err  = (m_md == 2'b11);            // R9
            m_cyc++;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (m_valid && !done) begin
            check({m_tag, " dac"}, dac, m_out);
            check(m_inrst ? "R1 mon" : "R2 R4 mon", mon, m_stat);
            check(m_inrst ? "R1 err" : "R9 err", err, m_err);
        end
    end

    task automatic run(input int n, input int md);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            mode = md[1:0];
            pa = 12'($urandom);
            pb = 12'($urandom);
        end
    endtask

    initial begin
        rst = 1; mode = 2'b00; pa = 12'h123; pb = 12'h456;
        repeat (3) @(negedge clk);
        rst = 0;
        run(40, 0);                 // R3 interleave
        run(7, 1);                  // R5, odd length shifts phase, R8
        run(20, 1);
        run(9, 2);                  // R6
        run(20, 2);
        run(11, 3);                 // R7 R9 illegal hold
        run(6, 0);
        run(5, 1);
        run(8, 3);
        run(13, 0);
        for (int i = 0; i < 60; i++) run(1, $urandom % 4);   // R8 every-cycle changes
        run(5, 0);
        @(negedge clk); rst = 1;    // R1 reset mid-pair
        run(3, 2);
        @(negedge clk); rst = 0;
        run(30, 0);
        run(30, 2);
        run(20, 0);
        @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule